// File: doc/BRIEF.md
# Mask-Based Signal Routing Matrix

This block steers a small set of single-bit source signals onto a wider bank of output lines. Every source has its own line-select mask. Each bit of that mask gates the source onto one output line, and each line carries the OR of all gated sources. One source may therefore drive any number of lines. Where masks overlap, the sources on a shared line merge.

A host loads the masks through a minimal register port. The port has a write enable, a mask select and a write data bus, and any mask can be read back through the same select. Masks may be rewritten while the sources are live, and the new routing applies from the clock edge that stores the write. Between the sources and the output lines there is only gating logic, with no registers.

A collision vector marks every output line that two or more masks claim. A single collision flag summarises that vector. Both depend only on the stored masks.

Top module: `mask_router`

## Requirements
- R1: While rst_ni is low, every mask is zero. As a result route_o, coll_vec_o and coll_o are all zero, and rdata_o reads zero for every select value.
- R2: On a rising clk_i edge with wr_en_i high, mask number addr_i (0 = source 0 … 3 = source 3) takes the value of wdata_i. The other masks keep their values.
- R3: rdata_o shows, within the same cycle, the mask whose number equals addr_i.
- R4: On a rising edge with wr_en_i low, no mask changes, whatever addr_i and wdata_i carry.
- R5: An output line is 0 if no mask has its bit set, or if every source whose mask bit is set for that line is 0.
- R6: route_o bit j is the OR, over all sources s, of src_i[s] AND bit j of mask s. Overlapping masks therefore give the OR of the sources involved.
- R7: A mask with several bits set makes every one of those lines follow its source. For example, mask 0x09 on source 0 drives lines 0 and 3.
- R8: route_o follows src_i combinationally, in the same cycle, with no clock edge in between.
- R9: coll_vec_o bit j is 1 exactly when at least two masks have bit j set.
- R10: coll_o is 1 exactly when some bit of coll_vec_o is 1. It does not change when src_i changes.
- R11: Rewriting a mask during operation, with no reset, changes route_o from the cycle after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source signals, bit s is source s |
| wr_en_i | input | 1 | Mask write enable |
| addr_i | input | SEL_W | Mask select for write and readback |
| wdata_i | input | NUM_LINES | Mask write data |
| rdata_o | output | NUM_LINES | Readback of selected mask |
| route_o | output | NUM_LINES | Routed output lines |
| coll_vec_o | output | NUM_LINES | Per-line collision marks |
| coll_o | output | 1 | Any-line collision flag |

## Verification
The bench builds the block with four sources and eight output lines. With that size, the four mask bits of each line can be assigned in sixteen rotated rounds, so every one of the sixteen per-line mask combinations appears on several lines, and every round is driven with all sixteen source values. This covers every gating, merging and collision case for a line, and it checks that the collision outputs stay unchanged while the sources sweep. Directed steps then cover reset, readback of every mask, writes with the enable low, a one-source-to-many-lines mask and a rewrite while the sources are live.

// File: rtl/mask_router_pkg.sv
package mask_router_pkg;
  localparam int unsigned DEF_SRC   = 4;
  localparam int unsigned DEF_LINES = 32;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mask_bank.sv
module mask_bank #(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [SEL_W-1:0]                    addr_i,
  input  logic [NUM_LINES-1:0]                wdata_i,
  output logic [NUM_SRC-1:0][NUM_LINES-1:0]   mask_o,
  output logic [NUM_LINES-1:0]                rdata_o
);
  logic [NUM_LINES-1:0] mask_q [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (addr_i == SEL_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mask_q[s] <= '0;
      else if (hit) mask_q[s] <= wdata_i;
    end

    assign mask_o[s] = mask_q[s];
  end

  // unmatched select values read as zero
  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (addr_i == SEL_W'(s)) rdata_o = mask_q[s];
  end
endmodule

// File: rtl/route_fabric.sv
module route_fabric #(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_SRC-1:0]                  src_i,
  input  logic [NUM_SRC-1:0][NUM_LINES-1:0]   mask_i,
  output logic [NUM_LINES-1:0]                route_o
);
  logic [NUM_SRC-1:0][NUM_LINES-1:0] gated;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    assign gated[s] = mask_i[s] & {NUM_LINES{src_i[s]}};
  end

  always_comb begin
    route_o = '0;
    for (int s = 0; s < NUM_SRC; s++) route_o |= gated[s];
  end
endmodule

// File: rtl/coll_detect.sv
module coll_detect #(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_SRC-1:0][NUM_LINES-1:0]   mask_i,
  output logic [NUM_LINES-1:0]                coll_vec_o,
  output logic                                coll_o
);
  // running scan: a line collides once a set bit meets an earlier set bit
  logic [NUM_LINES-1:0] seen;

  always_comb begin
    seen       = '0;
    coll_vec_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      coll_vec_o |= seen & mask_i[s];
      seen       |= mask_i[s];
    end
  end

  assign coll_o = |coll_vec_o;
endmodule

// File: rtl/mask_router.sv
module mask_router
  import mask_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = DEF_SRC,
  parameter int unsigned NUM_LINES = DEF_LINES,
  localparam int unsigned SEL_W    = sel_width(NUM_SRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      addr_i,
  input  logic [NUM_LINES-1:0]  wdata_i,
  output logic [NUM_LINES-1:0]  rdata_o,
  output logic [NUM_LINES-1:0]  route_o,
  output logic [NUM_LINES-1:0]  coll_vec_o,
  output logic                  coll_o
);
  logic [NUM_SRC-1:0][NUM_LINES-1:0] mask_w;

  mask_bank #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES),
    .SEL_W     (SEL_W)
  ) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mask_o  (mask_w),
    .rdata_o (rdata_o)
  );

  route_fabric #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES)
  ) i_fabric (
    .src_i   (src_i),
    .mask_i  (mask_w),
    .route_o (route_o)
  );

  coll_detect #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES)
  ) i_coll (
    .mask_i     (mask_w),
    .coll_vec_o (coll_vec_o),
    .coll_o     (coll_o)
  );
endmodule

// File: rtl/mask_router_checker.sv
module mask_router_checker #(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned SEL_W     = 2
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [NUM_SRC-1:0]                  src_i,
  input logic                                wr_en_i,
  input logic [SEL_W-1:0]                    addr_i,
  input logic [NUM_LINES-1:0]                wdata_i,
  input logic [NUM_LINES-1:0]                route_o,
  input logic [NUM_LINES-1:0]                coll_vec_o,
  input logic                                coll_o,
  input logic [NUM_SRC-1:0][NUM_LINES-1:0]   mask_i
);
  logic [NUM_LINES-1:0] union_m, pair_m;

  always_comb begin
    union_m = '0;
    pair_m  = '0;
    for (int a = 0; a < NUM_SRC; a++) begin
      union_m |= mask_i[a];
      for (int b = a + 1; b < NUM_SRC; b++) pair_m |= mask_i[a] & mask_i[b];
    end
  end

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (route_o == '0 && coll_vec_o == '0 && !coll_o);

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) < NUM_SRC) |=> mask_i[$past(addr_i)] == $past(wdata_i));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_i));

  assert_unmapped_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o & ~union_m) == '0);

  assert_all_on_union_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&src_i) |-> route_o == union_m);

  assert_pair_vector_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_vec_o == pair_m);

  assert_flag_any_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o == (pair_m != '0));
endmodule

bind mask_router mask_router_checker #(
  .NUM_SRC   (NUM_SRC),
  .NUM_LINES (NUM_LINES),
  .SEL_W     (SEL_W)
) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .route_o    (route_o),
  .coll_vec_o (coll_vec_o),
  .coll_o     (coll_o),
  .mask_i     (mask_w)
);

// File: tb/test_mask_router.sv
module test_mask_router;
  localparam int unsigned NS = 4;
  localparam int unsigned NL = 8;
  localparam int unsigned SW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] addr = '0;
  logic [NL-1:0] wdata = '0;
  logic [NL-1:0] rdata, route, coll_vec;
  logic          coll;

  int n_chk = 0;
  int n_bad = 0;
  logic [NL-1:0] mdl [NS];

  always #5 clk = ~clk;

  mask_router #(.NUM_SRC(NS), .NUM_LINES(NL)) i_mask_router (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .route_o    (route),
    .coll_vec_o (coll_vec),
    .coll_o     (coll)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [NL-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = SW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[a] = d;
  endtask

  function automatic logic [NL-1:0] exp_route(input logic [NS-1:0] s);
    logic [NL-1:0] r = '0;
    for (int k = 0; k < NS; k++) if (s[k]) r |= mdl[k];
    return r;
  endfunction

  function automatic logic [NL-1:0] exp_coll();
    logic [NL-1:0] v = '0;
    for (int j = 0; j < NL; j++) begin
      int c = 0;
      for (int k = 0; k < NS; k++) c += int'(mdl[k][j]);
      v[j] = (c >= 2);
    end
    return v;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) mdl[k] = '0;
    #1 rst_ni = 1'b0;
    src = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 route", 32'(route), 32'h0);
    chk("R1 coll_vec", 32'(coll_vec), 32'h0);
    chk("R1 coll", 32'(coll), 32'h0);
    for (int k = 0; k < NS; k++) begin
      addr = SW'(k); #1;
      chk("R1 rdata", 32'(rdata), 32'h0);
    end
    @(negedge clk) rst_ni = 1'b1;
    src = '0;

    // R2, R3: distinct values, full readback
    for (int k = 0; k < NS; k++) wr(k, NL'(8'h11 << k) | NL'(8'h80 >> k));
    for (int k = 0; k < NS; k++) begin
      addr = SW'(k); #1;
      chk("R2/R3 readback", 32'(rdata), 32'(mdl[k]));
    end

    // R4: enable low, bus busy
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd2; wdata = 8'hA5;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      addr = SW'(k); #1;
      chk("R4 no write", 32'(rdata), 32'(mdl[k]));
    end

    // rotated sweep: every per-line mask code against every source value
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < NS; k++) begin
        logic [NL-1:0] m = '0;
        for (int j = 0; j < NL; j++) m[j] = 1'((((r + j) & 15) >> k) & 1);
        wr(k, m);
      end
      #1;
      chk("R9 coll_vec", 32'(coll_vec), 32'(exp_coll()));
      chk("R10 coll", 32'(coll), 32'(exp_coll() != '0));
      for (int sv = 0; sv < 16; sv++) begin
        src = NS'(sv); #1;
        chk("R5/R6 route", 32'(route), 32'(exp_route(NS'(sv))));
        chk("R10 coll vs src", 32'(coll), 32'(exp_coll() != '0));
      end
    end

    // R8: same-cycle follow, no edge between
    @(negedge clk);
    wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    src = 4'h0; #1;
    chk("R8 low", 32'(route), 32'h00);
    #1 src = 4'h1; #1;
    chk("R8 same cycle", 32'(route), 32'hFF);

    // R7: one source to many lines
    wr(0, 8'h09);
    src = 4'h1; #1;
    chk("R7 fan-out", 32'(route), 32'h09);
    src = 4'h0; #1;
    chk("R5 source low", 32'(route), 32'h00);

    // R6: overlap merges
    wr(1, 8'h01);
    src = 4'h2; #1;
    chk("R6 overlap B only", 32'(route), 32'h01);
    chk("R9 overlap", 32'(coll_vec), 32'h01);

    // R11: live rewrite
    src = 4'h3;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R11 after edge", 32'(route), 32'h41);
    chk("R11 coll cleared", 32'(coll), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule